// File: doc/BRIEF.md
# Completion Queue Interrupt Gate

This block is a four-entry, in-order completion queue for load and store operations. It also decides when a pending interrupt may be accepted. Operations enter at the top with a tag and an operation kind. Finish pulses carrying a tag mark an entry done, and the bottom entry retires once it is done, with the rest of the queue moving down one place in the same cycle.

A guarded load may go to the bus only from the bottom entry. While the bottom entry is an unfinished guarded load or an unfinished cache-inhibited store-conditional, interrupts are held off. A bus error on such a load is reported as a tag-carrying clear-guarded pulse in place of the finish pulse. When that tag matches the bottom entry, its guarded attribute is dropped, the gate opens, and the interrupt is taken. Taking an interrupt flushes the queue.

A load-reserve sets a reservation when it finishes. A store-conditional consumes the reservation and reports a condition bit one cycle after it finishes. An address error on the store-conditional, or a snoop kill of the reservation, makes it report failure.

Top module: `cq_irq_gate`

## Requirements
- R1: After reset the queue is empty: `retire`, `guard_go`, `irq_take` and `sc_done` are 0, `disp_ok` is 1, and the reservation is clear, so a first store-conditional reports `sc_ok`=0.
- R2: `disp_kind` encodes 0 plain, 1 guarded load, 2 cache-inhibited store-conditional and 3 load-reserve. Entries retire strictly in dispatch order, one per cycle, when the bottom entry is finished (`retire`=1 and `retire_tag` = its tag, combinationally). `disp_ok` is 0 when all 4 entries are occupied and none retires.
- R3: A finish pulse marks every occupied entry whose tag equals `fin_tag` as finished. A pulse whose tag matches no occupied entry has no effect.
- R4: `guard_go` is 1 only while the bottom entry is an unfinished guarded load that still carries its guarded attribute. A guarded load in any other position never gets it.
- R5: No interrupt is accepted while the bottom entry is an unfinished guarded load or an unfinished store-conditional. With any other bottom entry, or an empty queue, a pending `irq_req` is accepted.
- R6: A clear-guarded pulse whose tag equals the bottom entry's tag removes that entry's guarded attribute without finishing it, which lets the interrupt be accepted. A clear-guarded pulse with any other tag, including the tag of a non-bottom entry, has no effect.
- R7: On acceptance, `irq_take` is high for exactly the one cycle after the accepting edge. The queue is emptied at that edge, and a dispatch offered in that cycle is refused.
- R8: A finished load-reserve sets the reservation. A store-conditional finishing with the reservation set, no address error and no snoop kill gives `sc_done`=1 and `sc_ok`=1 in the next cycle. Every store-conditional finish clears the reservation.
- R9: A store-conditional finishing with `sc_aerr`=1 still finishes and retires, reports `sc_ok`=0 and clears the reservation.
- R10: `snoop_kill` clears the reservation. In the same cycle as a load-reserve finish it wins over the set, and in the same cycle as a store-conditional finish it forces `sc_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Operation kind of the dispatched entry |
| disp_tag | input | TAG_W | Tag of the dispatched entry |
| disp_ok | output | 1 | Dispatch is accepted this cycle |
| fin_valid | input | 1 | Finish pulse |
| fin_tag | input | TAG_W | Tag of the finishing operation |
| clrg_valid | input | 1 | Clear-guarded pulse (bus error on a load) |
| clrg_tag | input | TAG_W | Tag carried by the clear-guarded pulse |
| sc_aerr | input | 1 | Address error qualifying a store-conditional finish |
| snoop_kill | input | 1 | Snoop reservation-kill event |
| irq_req | input | 1 | Interrupt pending (level) |
| retire | output | 1 | Bottom entry retires this cycle |
| retire_tag | output | TAG_W | Tag of the retiring entry |
| guard_go | output | 1 | Guarded load at the bottom may go to the bus |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | Store-conditional condition bit |
| irq_take | output | 1 | Interrupt accepted (one-cycle pulse) |

## Verification
On every cycle, the assertions hold the occupancy within the queue depth, keep `irq_take` from following a cycle in which the bottom entry blocks the gate, hold the take strobe to a single cycle with an empty queue, and keep the reservation cleared after any store-conditional result or snoop kill. Only the bench's scenarios can show the end-to-end effects. These include a clear-guarded pulse unblocking an interrupt only when its tag matches the bottom entry, an unmatched finish leaving the queue untouched, the flush refusing the dispatch offered with it, and how each error and snoop combination ends up in the condition bit. A behavioural queue model covers ordering and retirement under mixed random traffic.

// File: rtl/cq_pkg.sv
package cq_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_GLOAD  = 2'd1,
    OP_STCOND = 2'd2,
    OP_LDRES  = 2'd3
  } op_kind_e;

  // the bottom entry holds off interrupts while unfinished and guarded or store-conditional
  function automatic logic head_holds_irq(input logic occ, input logic done,
                                          input logic grd, input op_kind_e kind);
    return occ && !done && (grd || kind == OP_STCOND);
  endfunction

  // condition bit of a finishing store-conditional
  function automatic logic stcond_pass(input logic resv, input logic kill, input logic aerr);
    return resv && !kill && !aerr;
  endfunction

endpackage

// File: rtl/cq_slot.sv
module cq_slot #(
  parameter int TAG_W   = 4,
  parameter bit IS_HEAD = 1'b0
) (
  input  logic             occ,
  input  logic [TAG_W-1:0] tag,
  input  logic             grd,
  input  logic             done,
  input  logic             fin_valid,
  input  logic [TAG_W-1:0] fin_tag,
  input  logic             clrg_valid,
  input  logic [TAG_W-1:0] clrg_tag,
  output logic             nx_grd,
  output logic             nx_done,
  output logic             fin_hit
);
  logic clr_hit;

  assign fin_hit = occ && fin_valid && (fin_tag == tag) && !done;
  // only the bottom entry can be on the bus as a guarded load
  assign clr_hit = IS_HEAD && occ && clrg_valid && (clrg_tag == tag);
  assign nx_done = done || fin_hit;
  assign nx_grd  = grd && !clr_hit;
endmodule

// File: rtl/cq_resv.sv
module cq_resv (
  input  logic clk,
  input  logic rst_n,
  input  logic snoop_kill,
  input  logic sc_fin,
  input  logic lr_fin,
  input  logic sc_aerr,
  output logic sc_done,
  output logic sc_ok
);
  import cq_pkg::*;

  logic resv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_q  <= 1'b0;
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
    end else begin
      sc_done <= sc_fin;
      sc_ok   <= sc_fin && stcond_pass(resv_q, snoop_kill, sc_aerr);
      if (snoop_kill || sc_fin) resv_q <= 1'b0;
      else if (lr_fin)          resv_q <= 1'b1;
    end
  end

  // R8
  sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> !resv_q);
  // R10
  snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill |=> !resv_q);
  // R9
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> sc_done);
endmodule

// File: rtl/cq_irq_gate.sv
module cq_irq_gate #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [1:0]       disp_kind,
  input  logic [TAG_W-1:0] disp_tag,
  output logic             disp_ok,
  input  logic             fin_valid,
  input  logic [TAG_W-1:0] fin_tag,
  input  logic             clrg_valid,
  input  logic [TAG_W-1:0] clrg_tag,
  input  logic             sc_aerr,
  input  logic             snoop_kill,
  input  logic             irq_req,
  output logic             retire,
  output logic [TAG_W-1:0] retire_tag,
  output logic             guard_go,
  output logic             sc_done,
  output logic             sc_ok,
  output logic             irq_take
);
  import cq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] tag_q  [DEPTH];
  op_kind_e         kind_q [DEPTH];
  logic [DEPTH-1:0] grd_q, done_q;

  logic [TAG_W-1:0] nx_tag  [DEPTH];
  op_kind_e         nx_kind [DEPTH];
  logic [DEPTH-1:0] nx_g, nx_d;

  logic [DEPTH-1:0] occ, upd_grd, upd_done, fin_hit, is_sc, is_lr;
  logic             head_blk, acc, full, take_disp, sc_fin, lr_fin;
  logic [CNT_W-1:0] wr_pos;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign occ[i]   = CNT_W'(i) < cnt;
    assign is_sc[i] = kind_q[i] == OP_STCOND;
    assign is_lr[i] = kind_q[i] == OP_LDRES;
    cq_slot #(.TAG_W(TAG_W), .IS_HEAD(i == 0)) u_slot (
      .occ       (occ[i]),
      .tag       (tag_q[i]),
      .grd       (grd_q[i]),
      .done      (done_q[i]),
      .fin_valid (fin_valid),
      .fin_tag   (fin_tag),
      .clrg_valid(clrg_valid),
      .clrg_tag  (clrg_tag),
      .nx_grd    (upd_grd[i]),
      .nx_done   (upd_done[i]),
      .fin_hit   (fin_hit[i])
    );
  end

  assign sc_fin     = |(fin_hit & is_sc);
  assign lr_fin     = |(fin_hit & is_lr);
  assign head_blk   = head_holds_irq(occ[0], done_q[0], grd_q[0], kind_q[0]);
  assign acc        = irq_req && !head_blk && !irq_take;
  assign retire     = occ[0] && done_q[0];
  assign retire_tag = tag_q[0];
  assign guard_go   = occ[0] && grd_q[0] && !done_q[0];
  assign full       = cnt == CNT_W'(DEPTH);
  assign disp_ok    = !acc && (!full || retire);
  assign take_disp  = disp_valid && disp_ok;
  assign wr_pos     = cnt - CNT_W'(retire);

  always_comb begin
    int src;
    for (int i = 0; i < DEPTH; i++) begin
      src        = (retire && i < DEPTH - 1) ? i + 1 : i;
      nx_tag[i]  = tag_q[src];
      nx_kind[i] = kind_q[src];
      nx_g[i]    = upd_grd[src];
      nx_d[i]    = upd_done[src];
      if (take_disp && wr_pos == CNT_W'(i)) begin
        nx_tag[i]  = disp_tag;
        nx_kind[i] = op_kind_e'(disp_kind);
        nx_g[i]    = op_kind_e'(disp_kind) == OP_GLOAD;
        nx_d[i]    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      grd_q    <= '0;
      done_q   <= '0;
      irq_take <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        kind_q[i] <= OP_PLAIN;
      end
    end else begin
      cnt      <= acc ? '0 : cnt - CNT_W'(retire) + CNT_W'(take_disp);
      grd_q    <= nx_g;
      done_q   <= nx_d;
      irq_take <= acc;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= nx_tag[i];
        kind_q[i] <= nx_kind[i];
      end
    end
  end

  cq_resv u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .snoop_kill(snoop_kill),
    .sc_fin    (sc_fin),
    .lr_fin    (lr_fin),
    .sc_aerr   (sc_aerr),
    .sc_done   (sc_done),
    .sc_ok     (sc_ok)
  );

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_blk |=> !irq_take);
  // R7
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !irq_take);
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (cnt == '0));
endmodule

// File: tb/cq_irq_gate_test.sv
module cq_irq_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 0, fin_valid = 0, clrg_valid = 0, sc_aerr = 0, snoop_kill = 0, irq_req = 0;
  logic [1:0] disp_kind = 0;
  logic [3:0] disp_tag = 0, fin_tag = 0, clrg_tag = 0;
  logic       disp_ok, retire, guard_go, sc_done, sc_ok, irq_take;
  logic [3:0] retire_tag;

  int total = 0, bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  cq_irq_gate #(.DEPTH(4), .TAG_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
    .disp_tag(disp_tag), .disp_ok(disp_ok), .fin_valid(fin_valid), .fin_tag(fin_tag),
    .clrg_valid(clrg_valid), .clrg_tag(clrg_tag), .sc_aerr(sc_aerr),
    .snoop_kill(snoop_kill), .irq_req(irq_req), .retire(retire),
    .retire_tag(retire_tag), .guard_go(guard_go), .sc_done(sc_done),
    .sc_ok(sc_ok), .irq_take(irq_take)
  );

  // behavioural reference model
  typedef struct { int tag; int kind; bit grd; bit fin; } ment_t;
  ment_t mq[$];
  bit m_resv = 0, m_take = 0, m_scd = 0, m_sco = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_block();
    return mq.size() > 0 && !mq[0].fin && (mq[0].grd || mq[0].kind == 2);
  endfunction

  task automatic cyc();
    bit acc, rt, dok, scfin, lrfin;
    #1;
    acc = irq_req && !m_block() && !m_take;
    rt  = mq.size() > 0 && mq[0].fin;
    dok = !acc && (mq.size() < 4 || rt);
    chk("R2 retire", int'(retire), int'(rt));
    if (rt) chk("R2 retire_tag", int'(retire_tag), mq[0].tag);
    chk("R2 disp_ok", int'(disp_ok), int'(dok));
    chk("R4 guard_go", int'(guard_go),
        int'(mq.size() > 0 && mq[0].grd && !mq[0].fin));
    chk("R5 irq_take", int'(irq_take), int'(m_take));
    chk("R8 sc_done", int'(sc_done), int'(m_scd));
    chk("R8 sc_ok", int'(sc_ok), int'(m_sco));
    @(posedge clk);
    scfin = 0; lrfin = 0;
    if (fin_valid)
      foreach (mq[i])
        if (mq[i].tag == int'(fin_tag) && !mq[i].fin) begin
          mq[i].fin = 1;
          if (mq[i].kind == 2) scfin = 1;
          if (mq[i].kind == 3) lrfin = 1;
        end
    if (clrg_valid && mq.size() > 0 && mq[0].tag == int'(clrg_tag)) mq[0].grd = 0;
    m_scd = scfin;
    m_sco = scfin && m_resv && !snoop_kill && !sc_aerr;
    if (snoop_kill || scfin) m_resv = 0;
    else if (lrfin) m_resv = 1;
    if (rt) void'(mq.pop_front());
    if (acc) mq.delete();
    else if (disp_valid && dok) begin
      ment_t e;
      e.tag = int'(disp_tag); e.kind = int'(disp_kind); e.grd = (disp_kind == 2'd1); e.fin = 0;
      mq.push_back(e);
    end
    m_take = acc;
    @(negedge clk);
    disp_valid = 0; fin_valid = 0; clrg_valid = 0; sc_aerr = 0; snoop_kill = 0;
  endtask

  task automatic disp(int k, int t);
    disp_valid = 1; disp_kind = 2'(k); disp_tag = 4'(t); cyc();
  endtask
  task automatic fin(int t, bit err = 0);
    fin_valid = 1; fin_tag = 4'(t); sc_aerr = err; cyc();
  endtask
  task automatic clrg(int t);
    clrg_valid = 1; clrg_tag = 4'(t); cyc();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 retire", int'(retire), 0);
    chk("R1 guard_go", int'(guard_go), 0);
    chk("R1 irq_take", int'(irq_take), 0);
    chk("R1 sc_done", int'(sc_done), 0);
    chk("R1 disp_ok", int'(disp_ok), 1);
    @(negedge clk);
    disp(2, 7); fin(7);
    chk("R1 sc after reset", int'(sc_ok), 0);
    chk("R1 sc_done", int'(sc_done), 1);
    idle(2);

    // R2 / R3 ordering and unmatched finish
    disp(0, 1); disp(0, 2); disp(0, 3); disp(0, 4);
    chk("R2 full", int'(disp_ok), 0);
    fin(3);
    chk("R2 out-of-order finish holds", int'(retire), 0);
    fin(9);
    chk("R3 unmatched finish", int'(retire), 0);
    fin(1);
    chk("R2 head retire", int'(retire), 1);
    chk("R2 head tag", int'(retire_tag), 1);
    cyc();
    chk("R2 next head unfinished", int'(retire), 0);
    fin(2);
    chk("R2 tag2", int'(retire_tag), 2);
    cyc();
    chk("R2 tag3 follows", int'(retire_tag), 3);
    chk("R3 tag3 kept finish", int'(retire), 1);
    cyc();
    chk("R3 tag4 untouched by unmatched", int'(retire), 0);
    fin(4); idle(1);

    // R4 / R5 / R6 / R7 guarded load blocking
    disp(0, 4); disp(1, 5); disp(0, 6);
    chk("R4 guarded not at bottom", int'(guard_go), 0);
    fin(4); cyc();
    chk("R4 guarded at bottom", int'(guard_go), 1);
    irq_req = 1;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R5 blocked by guarded", int'(irq_take), 0);
    end
    clrg(6);
    chk("R6 non-bottom clear", int'(guard_go), 1);
    clrg(7);
    chk("R6 wrong tag clear", int'(guard_go), 1);
    chk("R6 still blocked", int'(irq_take), 0);
    clrg(5);
    chk("R6 guard dropped", int'(guard_go), 0);
    disp(0, 8);
    chk("R7 take after clear", int'(irq_take), 1);
    irq_req = 0;
    cyc();
    chk("R7 single pulse", int'(irq_take), 0);
    fin(6); fin(8);
    chk("R7 flushed", int'(retire), 0);
    chk("R7 empty", int'(disp_ok), 1);

    // R5 accepted with plain head
    disp(0, 9);
    irq_req = 1; cyc(); irq_req = 0;
    chk("R5 plain head accepts", int'(irq_take), 1);
    idle(1);

    // R8 reservation success then consumption; SC blocks interrupts
    disp(3, 1); fin(1); disp(2, 2);
    irq_req = 1; cyc();
    chk("R5 blocked by store-conditional", int'(irq_take), 0);
    irq_req = 0;
    fin(2);
    chk("R8 success", int'(sc_ok), 1);
    chk("R8 done", int'(sc_done), 1);
    cyc();
    chk("R8 done pulse", int'(sc_done), 0);
    disp(2, 3); fin(3);
    chk("R8 reservation consumed", int'(sc_ok), 0);
    idle(2);

    // R9 address error
    disp(3, 4); fin(4); disp(2, 5); fin(5, 1);
    chk("R9 error fails", int'(sc_ok), 0);
    chk("R9 still finishes", int'(retire), 1);
    cyc();
    disp(2, 6); fin(6);
    chk("R9 reservation cleared", int'(sc_ok), 0);
    idle(2);

    // R10 snoop kills
    disp(3, 1); fin(1); snoop_kill = 1; cyc();
    disp(2, 2); fin(2);
    chk("R10 snoop before sc", int'(sc_ok), 0);
    idle(1);
    disp(3, 3); snoop_kill = 1; fin(3);
    disp(2, 4); fin(4);
    chk("R10 snoop beats set", int'(sc_ok), 0);
    idle(1);
    disp(3, 5); fin(5); disp(2, 6); snoop_kill = 1; fin(6);
    chk("R10 snoop with sc finish", int'(sc_ok), 0);
    chk("R10 done", int'(sc_done), 1);
    idle(2);

    // mixed traffic against the model
    begin
      int nt = 0;
      for (int c = 0; c < 600; c++) begin
        disp_valid = ($urandom_range(0, 2) != 0);
        disp_kind  = 2'($urandom_range(0, 3));
        disp_tag   = 4'(nt);
        if (disp_valid && disp_ok) nt = (nt + 1) % 16;
        fin_valid  = ($urandom_range(0, 1) != 0);
        fin_tag    = 4'($urandom_range(0, 15));
        clrg_valid = ($urandom_range(0, 5) == 0);
        clrg_tag   = mq.size() > 0 && $urandom_range(0, 1) ? 4'(mq[0].tag) : 4'($urandom_range(0, 15));
        sc_aerr    = ($urandom_range(0, 3) == 0);
        snoop_kill = ($urandom_range(0, 7) == 0);
        irq_req    = ($urandom_range(0, 9) == 0);
        cyc();
      end
      irq_req = 0;
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule